// File: doc/BRIEF.md
# Four-Channel Bit-Serial Thermometer Controller

This block sits on a simple register bus and controls four identical bit-serial thermometer channels through one shared command stream. Each channel has its own bit lane. Software works through three registers:

- **Control register.** Raises a serial reset or moves the serial clock low or high.
- **Data-write register.** Each access pushes one bit, either of the command or of write data.
- **Data-read register.** Each access returns the current bit of every channel at once. Channel i appears in bit i.

Temperature conversion is not modelled. Every channel holds a preset temperature and a preset configuration status.

The sequencer has four named states:

- **ST_CMD.** Collects the 8 command bits.
- **ST_RDCFG.** Serves configuration reads.
- **ST_RDTMP.** Serves temperature reads.
- **ST_WDATA.** Entered after any command the block does not recognise. Later accepted writes fill a data register.

The state transitions are:

- **ST_CMD to ST_RDCFG, ST_RDTMP or ST_WDATA.** Taken when the eighth command bit is accepted, according to the command value.
- **ST_CMD to ST_CMD, cleared.** Taken on the start-conversion command.
- **ST_RDCFG or ST_RDTMP back to ST_CMD.** Taken on the read of the last bit of the transfer.
- **Any state to ST_CMD.** Taken on a control-register reset.

Software reads a channel value in three steps. It writes clock-low, then shifts in a read command one bit per access, then reads the data register once per bit.

Top module: `thermo_serial_if`

## Requirements
- R1: After rst_n is released, rd_data and wdata_bits are 0, the sequencer is in ST_CMD and the clock-low flag is clear. A data-read access then returns 0.
- R2: Register addresses are 0 for control, 1 for data-write and 2 for data-read. Control codes are 0x01 (serial reset), 0x02 (set clock-low flag) and 0x03 (clear clock-low flag). Other control codes are ignored. The serial reset clears the command, both positions and the data register, and returns to ST_CMD. It leaves the clock-low flag unchanged.
- R3: A data-write access with the clock-low flag clear and a code other than 0x80 changes nothing.
- R4: Data-write code 0x80 zeroes the data position whether or not the clock-low flag is set. It does nothing else.
- R5: In ST_CMD, each accepted data write fills the next command bit, starting at bit 0. Code 0x01 writes a 1 and any other code writes a 0.
- R6: When the 8-bit command is complete and equals 0xEE (start conversion), the serial state is cleared at once and a new command can follow immediately.
- R7: Command 0xAA selects temperature reads. Each data-read returns bit p of each channel's 9-bit temperature (preset 44, half-degree units) in rd_data[i], with rd_data[7:4] = 0, and then advances p.
- R8: Command 0xAC selects configuration reads. Each data-read returns bit p of each channel's 8-bit status (preset 0x4A) and advances p.
- R9: The read of the last bit (bit 8 for temperature, bit 7 for configuration) clears the serial state. The following data-read returns 0.
- R10: Any other complete command enters ST_WDATA. There, data-reads return 0 and do not move the position. Accepted writes set wdata_bits starting at bit 0 (code 0x01 = 1). The position stops at 9 and further bits are dropped.
- R11: rd_data is registered. It updates only in the cycle after an rd_en strobe, holds otherwise, and is loaded with 0 by a read of any address other than 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 2 | Register select |
| wr_data | input | 8 | Write code |
| rd_data | output | 8 | Registered read data, channel i in bit i |
| wdata_bits | output | 9 | Data bits shifted in after an unrecognised command |

## Verification
The assertions assume that wr_en and rd_en are never high in the same cycle, and that each strobe lasts exactly one clock with a stable address and code. The bench drives every access as a one-cycle pulse on the falling edge, so no two strobes ever overlap. Random codes, including unlisted control values and stray data codes, are confined to valid single accesses. Read-command traffic is mixed in often enough that transfers run to their automatic end.

// File: rtl/thermo_pkg.sv
package thermo_pkg;
    parameter int CODE_W = 8;

    // register addresses
    parameter logic [1:0] ADDR_CTRL = 2'd0;
    parameter logic [1:0] ADDR_DWR  = 2'd1;
    parameter logic [1:0] ADDR_DRD  = 2'd2;

    // control codes
    parameter logic [CODE_W-1:0] CTL_RESET = 8'h01;
    parameter logic [CODE_W-1:0] CTL_CLKLO = 8'h02;
    parameter logic [CODE_W-1:0] CTL_CLKHI = 8'h03;

    // data-write codes
    parameter logic [CODE_W-1:0] DW_HIGH = 8'h01;
    parameter logic [CODE_W-1:0] DW_ENRD = 8'h80;

    // serial commands
    parameter logic [7:0] CMD_CONVERT = 8'hEE;
    parameter logic [7:0] CMD_RDCFG   = 8'hAC;
    parameter logic [7:0] CMD_RDTMP   = 8'hAA;

    typedef enum logic [1:0] {
        ST_CMD   = 2'd0,
        ST_RDCFG = 2'd1,
        ST_RDTMP = 2'd2,
        ST_WDATA = 2'd3
    } th_state_e;
endpackage

// File: rtl/thermo_lane.sv
module thermo_lane
    import thermo_pkg::*;
#(
    parameter int CFG_LEN  = 8,
    parameter int TEMP_LEN = 9,
    parameter int POS_W    = 4,
    parameter logic [CFG_LEN-1:0]  CFG_INIT  = 8'h4A,
    parameter logic [TEMP_LEN-1:0] TEMP_INIT = 9'd44
) (
    input  logic             pick_cfg,
    input  logic             pick_tmp,
    input  logic [POS_W-1:0] pos,
    output logic             lane_bit
);
    logic [CFG_LEN-1:0]  cfg_sh;
    logic [TEMP_LEN-1:0] tmp_sh;

    always_comb begin
        cfg_sh   = CFG_INIT >> pos;
        tmp_sh   = TEMP_INIT >> pos;
        lane_bit = 1'b0;
        if (pick_cfg)      lane_bit = cfg_sh[0];
        else if (pick_tmp) lane_bit = tmp_sh[0];
    end
endmodule

// File: rtl/thermo_seq.sv
module thermo_seq
    import thermo_pkg::*;
#(
    parameter int CMD_LEN  = 8,
    parameter int CFG_LEN  = 8,
    parameter int TEMP_LEN = 9,
    parameter int DATA_W   = 9,
    parameter int POS_W    = 4,
    parameter int CPOS_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              dat_wr,
    input  logic              dat_rd,
    input  logic [CODE_W-1:0] code,
    output th_state_e         state_q,
    output logic [POS_W-1:0]  data_pos_q,
    output logic [DATA_W-1:0] data_q
);
    th_state_e           state_d;
    logic [CMD_LEN-1:0]  cmd_q, cmd_ext;
    logic [CPOS_W-1:0]   cmd_pos_q;
    logic                clk_low_q;
    logic                accept, bit_hi, cmd_last, clear_all;

    assign bit_hi   = (code == DW_HIGH);
    assign accept   = dat_wr && (code != DW_ENRD) && clk_low_q;
    assign cmd_ext  = cmd_q | (CMD_LEN'(bit_hi) << cmd_pos_q);
    assign cmd_last = (cmd_pos_q == CPOS_W'(CMD_LEN-1));

    // next-state logic
    always_comb begin
        state_d   = state_q;
        clear_all = 1'b0;
        if (ctl_wr && code == CTL_RESET) begin
            clear_all = 1'b1;
        end else begin
            unique case (state_q)
                ST_CMD: begin
                    if (accept && cmd_last) begin
                        if (cmd_ext == CMD_LEN'(CMD_CONVERT))    clear_all = 1'b1;
                        else if (cmd_ext == CMD_LEN'(CMD_RDCFG)) state_d = ST_RDCFG;
                        else if (cmd_ext == CMD_LEN'(CMD_RDTMP)) state_d = ST_RDTMP;
                        else                                     state_d = ST_WDATA;
                    end
                end
                ST_RDCFG: if (dat_rd && data_pos_q >= POS_W'(CFG_LEN-1))  clear_all = 1'b1;
                ST_RDTMP: if (dat_rd && data_pos_q >= POS_W'(TEMP_LEN-1)) clear_all = 1'b1;
                ST_WDATA: ;
                default:  state_d = ST_CMD;
            endcase
        end
        if (clear_all) state_d = ST_CMD;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_CMD;
        else        state_q <= state_d;
    end

    // serial datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_low_q  <= 1'b0;
            cmd_q      <= '0;
            cmd_pos_q  <= '0;
            data_q     <= '0;
            data_pos_q <= '0;
        end else begin
            if (ctl_wr && code == CTL_CLKLO) clk_low_q <= 1'b1;
            if (ctl_wr && code == CTL_CLKHI) clk_low_q <= 1'b0;
            if (clear_all) begin
                cmd_q      <= '0;
                cmd_pos_q  <= '0;
                data_q     <= '0;
                data_pos_q <= '0;
            end else if (dat_wr && code == DW_ENRD) begin
                data_pos_q <= '0;
            end else if (accept) begin
                if (state_q == ST_CMD) begin
                    cmd_q     <= cmd_ext;
                    cmd_pos_q <= cmd_pos_q + 1'b1;
                end else if (data_pos_q < POS_W'(DATA_W)) begin
                    if (bit_hi) data_q <= data_q | (DATA_W'(1) << data_pos_q);
                    data_pos_q <= data_pos_q + 1'b1;
                end
            end else if (dat_rd && (state_q == ST_RDCFG || state_q == ST_RDTMP)) begin
                data_pos_q <= data_pos_q + 1'b1;
            end
        end
    end

    // R2
    rst_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && code == CTL_RESET) |=> (state_q == ST_CMD && cmd_pos_q == '0 && data_pos_q == '0 && data_q == '0));

    // R3
    gated_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !clk_low_q && code != DW_ENRD)
        |=> ($stable(cmd_q) && $stable(cmd_pos_q) && $stable(state_q) && $stable(data_q) && $stable(data_pos_q)));

    // R4
    enrd_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && code == DW_ENRD) |=> (data_pos_q == '0));

    // R9
    rdtmp_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_rd && state_q == ST_RDTMP && data_pos_q == POS_W'(TEMP_LEN-1))
        |=> (state_q == ST_CMD && data_pos_q == '0 && cmd_pos_q == '0));

    // R10
    wdata_noadv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_rd && (state_q == ST_WDATA || state_q == ST_CMD))
        |=> ($stable(data_pos_q) && $stable(data_q)));
endmodule

// File: rtl/thermo_serial_if.sv
module thermo_serial_if
    import thermo_pkg::*;
#(
    parameter int N_SENSE  = 4,
    parameter int RD_W     = 8,
    parameter int CMD_LEN  = 8,
    parameter int CFG_LEN  = 8,
    parameter int TEMP_LEN = 9,
    parameter logic [CFG_LEN-1:0]  CFG_PRESET  = 8'h4A,
    parameter logic [TEMP_LEN-1:0] TEMP_PRESET = 9'd44,
    localparam int DATA_W = (TEMP_LEN > CFG_LEN) ? TEMP_LEN : CFG_LEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [CODE_W-1:0] wr_data,
    output logic [RD_W-1:0]   rd_data,
    output logic [DATA_W-1:0] wdata_bits
);
    localparam int POS_W  = $clog2(DATA_W + 1);
    localparam int CPOS_W = $clog2(CMD_LEN + 1);

    th_state_e          state;
    logic [POS_W-1:0]   data_pos;
    logic [N_SENSE-1:0] lane_bits;
    logic               ctl_wr, dat_wr, dat_rd;

    assign ctl_wr = wr_en && (addr == ADDR_CTRL);
    assign dat_wr = wr_en && (addr == ADDR_DWR);
    assign dat_rd = rd_en && (addr == ADDR_DRD);

    thermo_seq #(
        .CMD_LEN(CMD_LEN), .CFG_LEN(CFG_LEN), .TEMP_LEN(TEMP_LEN),
        .DATA_W(DATA_W), .POS_W(POS_W), .CPOS_W(CPOS_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .dat_wr(dat_wr),
        .dat_rd(dat_rd), .code(wr_data), .state_q(state),
        .data_pos_q(data_pos), .data_q(wdata_bits)
    );

    for (genvar g = 0; g < N_SENSE; g++) begin : g_lane
        thermo_lane #(
            .CFG_LEN(CFG_LEN), .TEMP_LEN(TEMP_LEN), .POS_W(POS_W),
            .CFG_INIT(CFG_PRESET), .TEMP_INIT(TEMP_PRESET)
        ) u_lane (
            .pick_cfg(state == ST_RDCFG),
            .pick_tmp(state == ST_RDTMP),
            .pos(data_pos),
            .lane_bit(lane_bits[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= (addr == ADDR_DRD) ? RD_W'(lane_bits) : '0;
    end

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R11
    rd_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr != ADDR_DRD) |=> (rd_data == '0));

    // R7
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[RD_W-1:N_SENSE] == '0);

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en));
endmodule

// File: tb/tb_thermo_serial_if.sv
`timescale 1ns/1ps
module tb_thermo_serial_if;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic [8:0] wdata_bits;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    localparam logic [7:0] CFGV = 8'h4A;
    localparam logic [8:0] TMPV = 9'd44;

    // reference model state
    int         m_st = 0;      // 0 cmd, 1 cfg, 2 tmp, 3 wdata
    bit         m_clk = 0;
    logic [7:0] m_cmd = 0;
    int         m_cpos = 0;
    int         m_dpos = 0;
    logic [8:0] m_data = 0;

    thermo_serial_if dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .wdata_bits(wdata_bits)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic m_clear();
        m_st = 0; m_cmd = 0; m_cpos = 0; m_dpos = 0; m_data = 0;
    endtask

    task automatic m_write(input logic [1:0] a, input logic [7:0] d);
        if (a == 2'd0) begin
            if (d == 8'h01) m_clear();
            else if (d == 8'h02) m_clk = 1;
            else if (d == 8'h03) m_clk = 0;
        end else if (a == 2'd1) begin
            if (d == 8'h80) m_dpos = 0;
            else if (m_clk) begin
                if (m_st == 0) begin
                    if (d == 8'h01) m_cmd[m_cpos] = 1'b1;
                    m_cpos++;
                    if (m_cpos == 8) begin
                        if (m_cmd == 8'hEE) m_clear();
                        else if (m_cmd == 8'hAC) m_st = 1;
                        else if (m_cmd == 8'hAA) m_st = 2;
                        else m_st = 3;
                    end
                end else if (m_dpos < 9) begin
                    if (d == 8'h01) m_data[m_dpos] = 1'b1;
                    m_dpos++;
                end
            end
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [1:0] a);
        logic b;
        if (a != 2'd2) return 8'h00;
        if (m_st == 1)      b = (m_dpos < 8) ? CFGV[m_dpos] : 1'b0;
        else if (m_st == 2) b = (m_dpos < 9) ? TMPV[m_dpos] : 1'b0;
        else return 8'h00;
        return {4'b0000, {4{b}}};
    endfunction

    task automatic m_read(input logic [1:0] a);
        if (a == 2'd2 && (m_st == 1 || m_st == 2)) begin
            m_dpos++;
            if (m_st == 1 && m_dpos >= 8) m_clear();
            else if (m_st == 2 && m_dpos >= 9) m_clear();
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        m_write(a, d);
    endtask

    task automatic do_rd(input string req, input logic [1:0] a);
        logic [7:0] e;
        e = exp_rd(a);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        m_read(a);
        chk(req, {8'h00, rd_data}, {8'h00, e});
    endtask

    task automatic send_cmd(input logic [7:0] c, input logic [7:0] lowcode);
        for (int i = 0; i < 8; i++) bus_wr(2'd1, c[i] ? 8'h01 : lowcode);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rd_data", {8'h00, rd_data}, 16'h0);
        chk("R1 wdata", {7'h00, wdata_bits}, 16'h0);
        do_rd("R1 read after reset", 2'd2);

        // R3 command without clock-low is ignored
        send_cmd(8'hAA, 8'h00);
        do_rd("R3 ignored cmd", 2'd2);
        chk("R3 wdata", {7'h00, wdata_bits}, 16'h0);

        // R7 temperature read, R9 auto reset
        bus_wr(2'd0, 8'h02);
        send_cmd(8'hAA, 8'h00);
        for (int i = 0; i < 9; i++) do_rd("R7 temp bit", 2'd2);
        do_rd("R9 after temp", 2'd2);

        // R8 config read, R9 auto reset
        send_cmd(8'hAC, 8'h00);
        for (int i = 0; i < 8; i++) do_rd("R8 cfg bit", 2'd2);
        do_rd("R9 after cfg", 2'd2);

        // R4 enable-read rewinds, with flag low then high
        send_cmd(8'hAA, 8'h00);
        for (int i = 0; i < 3; i++) do_rd("R7 partial", 2'd2);
        bus_wr(2'd1, 8'h80);
        do_rd("R4 rewind low", 2'd2);
        do_rd("R4 next", 2'd2);
        do_rd("R4 next2", 2'd2);
        bus_wr(2'd0, 8'h03);
        bus_wr(2'd1, 8'h80);
        do_rd("R4 rewind high", 2'd2);
        bus_wr(2'd0, 8'h02);
        bus_wr(2'd0, 8'h01);
        do_rd("R2 reset clears", 2'd2);

        // R6 start conversion
        send_cmd(8'hEE, 8'h00);
        do_rd("R6 after convert", 2'd2);
        send_cmd(8'hAA, 8'h00);
        do_rd("R6 cmd after convert", 2'd2);
        do_rd("R6 cmd after convert b1", 2'd2);
        bus_wr(2'd0, 8'h01);

        // R5 non-high codes count as zero
        send_cmd(8'hAA, 8'h7E);
        do_rd("R5 stray low codes", 2'd2);
        do_rd("R5 stray low codes b1", 2'd2);
        do_rd("R5 stray low codes b2", 2'd2);
        bus_wr(2'd0, 8'h01);

        // R2 reset mid-command
        for (int i = 0; i < 4; i++) bus_wr(2'd1, 8'h01);
        bus_wr(2'd0, 8'h01);
        send_cmd(8'hAC, 8'h00);
        do_rd("R2 cmd after reset", 2'd2);
        do_rd("R2 cmd after reset b1", 2'd2);
        bus_wr(2'd0, 8'h01);

        // R10 unrecognised command
        send_cmd(8'h5A, 8'h00);
        do_rd("R10 read zero", 2'd2);
        do_rd("R10 read zero again", 2'd2);
        bus_wr(2'd1, 8'h01);
        bus_wr(2'd1, 8'h00);
        bus_wr(2'd1, 8'h01);
        bus_wr(2'd1, 8'h01);
        chk("R10 wdata pattern", {7'h00, wdata_bits}, 16'h000D);
        for (int i = 0; i < 7; i++) bus_wr(2'd1, 8'h01);
        chk("R10 saturate", {7'h00, wdata_bits}, 16'h01FD);

        // R11 other addresses, hold
        bus_wr(2'd0, 8'h01);
        send_cmd(8'hAA, 8'h00);
        do_rd("R7 bit0", 2'd2);
        do_rd("R7 bit1", 2'd2);
        do_rd("R7 bit2", 2'd2);
        repeat (3) @(negedge clk);
        chk("R11 hold", {8'h00, rd_data}, 16'h000F);
        do_rd("R11 other addr", 2'd0);
        do_rd("R11 other addr 3", 2'd3);
        bus_wr(2'd2, 8'h01);
        do_rd("R11 write to read addr", 2'd2);

        // random mix
        for (int k = 0; k < 2500; k++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 8) begin
                bus_wr(2'd0, 8'($urandom_range(0, 4)));
            end else if (r < 14) begin
                int p;
                p = $urandom_range(0, 3);
                send_cmd(p == 0 ? 8'hAA : p == 1 ? 8'hAC : p == 2 ? 8'hEE : 8'($urandom), 8'h00);
            end else if (r < 55) begin
                int s;
                logic [7:0] d;
                s = $urandom_range(0, 19);
                d = (s < 9) ? 8'h01 : (s < 17) ? 8'h00 : (s == 17) ? 8'h80 : 8'($urandom);
                bus_wr(2'd1, d);
                chk("R10 rnd wdata", {7'h00, wdata_bits}, {7'h00, m_data});
            end else begin
                int a;
                a = $urandom_range(0, 5);
                do_rd("R7 rnd read", (a > 3) ? 2'd2 : 2'(a));
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule